// File: doc/BRIEF.md
# Two-Key Refresh Watchdog Timer

This block is a watchdog timer that software controls through three byte-wide registers on a simple synchronous bus. The bus has a write port with address and data, and a read port that returns data combinationally. Bit 6 of each register has a watchdog role: a refresh-arm flag, a start/refresh flag and a read-only "started" status. The other seven bits of each register are plain storage for neighbouring logic and have no effect on the watchdog.

Writing the start/refresh flag while the watchdog is idle starts it. Once it runs, software can restart the countdown only with an ordered pair of writes: first the arm flag, then the start/refresh flag as the very next bus write. Both flags clear themselves a fixed number of clocks after they are set. If the countdown runs out, the block raises a system reset request for one clock and returns all watchdog state to idle. Software cannot stop the watchdog.

Top module: `wdt_twokey`

## Requirements
- R1: Address 0 bit 6 reads the arm flag, address 1 bit 6 reads the start/refresh flag, address 2 bit 6 reads the started status, and address 3 reads as zero. rd_data follows rd_addr in the same cycle. After reset every register reads zero and rst_req is low.
- R2: Bits 7 and 5..0 of addresses 0, 1 and 2 hold the last value written and read it back unchanged. They never affect the watchdog. Writes to address 3 are discarded.
- R3: A write to address 0 with bit 6 set makes the arm flag read 1 for exactly 12 cycles after that write's clock edge, then 0. Writing it again while set restarts the 12 cycles. Writing bit 6 as 0 leaves the flag unchanged.
- R4: The start/refresh flag at address 1 behaves in the same way: it is set by writing 1 to bit 6, it self-clears after 12 cycles, and it ignores a written 0.
- R5: The status bit becomes 1 at the clock edge of a start/refresh write made while the watchdog is idle. Writes to address 2 bit 6 are ignored. Only an expiry or rst clears the status bit.
- R6: A start loads the countdown with TIMEOUT. Without a refresh, rst_req is high during the cycle that follows the TIMEOUT-th clock edge after the loading edge.
- R7: While the watchdog runs, a start/refresh write reloads the countdown to TIMEOUT only when the previous bus write was an arm write and the arm flag still reads 1.
- R8: A start/refresh write without a valid arm write before it does not reload the countdown. A bus write to any address between the arm write and the start write cancels the arm.
- R9: If the arm flag has already self-cleared, a following start/refresh write does not refresh the countdown.
- R10: On expiry, rst_req is high for exactly one cycle. In that cycle the status bit and both flags read 0, and the stored bits of R2 keep their values.
- R11: A valid refresh whose write edge falls in the final count cycle takes priority over expiry: the countdown reloads and no rst_req is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| rst_req | output | 1 | One-clock system reset request on timeout |

## Verification
A write takes effect at the clock edge where wr_en is sampled high. The flags and the status bit read back on the next read after that edge, because rd_data is combinational from register state. A flag set at edge E reads 1 up to edge E+12. rst_req rises at the TIMEOUT-th edge after the loading edge and falls at the next edge. The bench drives inputs and samples outputs on the falling edge. At each falling edge it compares rst_req and the selected read word against a behavioural model that is updated at the rising edge, so every result is checked in the cycle it is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_AW  = 2;
    localparam int REG_DW  = 8;
    localparam int CTL_BIT = 6;
    localparam logic [REG_DW-1:0] KEEP_MASK = ~(REG_DW'(1) << CTL_BIT);

    typedef enum logic [REG_AW-1:0] {
        ADR_ARM   = 2'd0,
        ADR_START = 2'd1,
        ADR_STAT  = 2'd2,
        ADR_VOID  = 2'd3
    } reg_adr_e;
endpackage

// File: rtl/wdt_selfclr.sv
module wdt_selfclr #(
    parameter int CLR_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    localparam int CW = $clog2(CLR_CYC + 1);

    typedef struct packed {
        logic          flag;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (set) begin
            st_d.flag = 1'b1;
            st_d.cnt  = CW'(CLR_CYC);
        end else if (st_q.flag) begin
            if (st_q.cnt == CW'(1)) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R3 / R4: a set that is not overridden is visible after the edge
    a_r3_set_visible: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> flag);
    // R3 / R4: the flag never rises without a set request
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!set) |=> !$rose(flag));
endmodule

// File: rtl/wdt_seqchk.sv
module wdt_seqchk (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic arm_wr,
    input  logic start_wr,
    input  logic arm_flag,
    input  logic clr,
    output logic refresh_ok
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)        st_d.armed = 1'b0;
        else if (wr_en) st_d.armed = arm_wr;
        else            st_d.armed = st_q.armed & arm_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign refresh_ok = start_wr & st_q.armed & arm_flag;

    // R8: any write that is not an arm write drops the armed state
    a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !arm_wr) |=> !refresh_ok);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_wr,
    input  logic refresh_ok,
    output logic running,
    output logic expire,
    output logic rst_req
);
    localparam int TW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          run;
        logic          req;
        logic [TW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    always_comb begin
        load   = (start_wr & ~st_q.run) | refresh_ok;
        expire = st_q.run & (st_q.cnt == TW'(1)) & ~load;
        st_d     = st_q;
        st_d.req = expire;
        if (load) begin
            st_d.run = 1'b1;
            st_d.cnt = TW'(TIMEOUT);
        end else if (expire) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign running = st_q.run;
    assign rst_req = st_q.req;

    // R10: the reset request lasts a single cycle
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    // R10: the watchdog is idle while the request is high
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !running);
    // R5: once started, only expiry stops it
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (running && !expire) |=> running);
    // R7 / R11: a load restores the full count
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (start_wr && refresh_ok) |=> (st_q.cnt == TW'(TIMEOUT)));
    // R8: without a load the count only moves down by one
    a_r8_steps: assert property (@(posedge clk) disable iff (rst)
        (running && !start_wr && st_q.cnt > TW'(1)) |=> (st_q.cnt == $past(st_q.cnt) - TW'(1)));
endmodule

// File: rtl/wdt_twokey.sv
module wdt_twokey
    import wdt_pkg::*;
#(
    parameter int TIMEOUT = 1000,
    parameter int CLR_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    output logic              rst_req
);
    localparam int NREG = 3;

    typedef struct packed {
        logic [NREG-1:0][REG_DW-1:0] keep;
    } st_t;

    st_t  st_d, st_q;
    logic arm_wr, start_wr;
    logic arm_flag, start_flag, running, expire, refresh_ok;

    assign arm_wr   = wr_en & (wr_addr == ADR_ARM)   & wr_data[CTL_BIT];
    assign start_wr = wr_en & (wr_addr == ADR_START) & wr_data[CTL_BIT];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && wr_addr == REG_AW'(i)) begin
                st_d.keep[i] = wr_data & KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    wdt_selfclr #(.CLR_CYC(CLR_CYC)) u_arm (
        .clk(clk), .rst(rst), .set(arm_wr), .clr(expire), .flag(arm_flag)
    );

    wdt_selfclr #(.CLR_CYC(CLR_CYC)) u_start (
        .clk(clk), .rst(rst), .set(start_wr), .clr(expire), .flag(start_flag)
    );

    wdt_seqchk u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .arm_wr(arm_wr),
        .start_wr(start_wr), .arm_flag(arm_flag), .clr(expire),
        .refresh_ok(refresh_ok)
    );

    wdt_countdown #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk(clk), .rst(rst), .start_wr(start_wr), .refresh_ok(refresh_ok),
        .running(running), .expire(expire), .rst_req(rst_req)
    );

    always_comb begin
        unique case (rd_addr)
            ADR_ARM:   rd_data = st_q.keep[0] | (REG_DW'(arm_flag)   << CTL_BIT);
            ADR_START: rd_data = st_q.keep[1] | (REG_DW'(start_flag) << CTL_BIT);
            ADR_STAT:  rd_data = st_q.keep[2] | (REG_DW'(running)    << CTL_BIT);
            default:   rd_data = '0;
        endcase
    end

    // R10: on a reset request the control bits all read as cleared
    a_r10_cleared: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (!arm_flag && !start_flag && !running));
    // R2: the stored bits never carry the control bit
    a_r2_masked: assert property (@(posedge clk) disable iff (rst)
        (st_q.keep[0][CTL_BIT] == 1'b0) && (st_q.keep[2][CTL_BIT] == 1'b0));
endmodule

// File: tb/wdt_twokey_bench.sv
module wdt_twokey_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO  = 40;
    localparam int CLR = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rst_req;

    wdt_twokey #(.TIMEOUT(TO), .CLR_CYC(CLR)) u_wdt_twokey (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    int   m_arm, m_st, m_cnt;
    bit   m_armed, m_run, m_rr;
    logic [7:0] m_keep [3];
    bit   wa, ws, rf, ld, ex;

    int unsigned n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_arm = 0; m_st = 0; m_cnt = 0;
            m_armed = 0; m_run = 0; m_rr = 0;
            for (int i = 0; i < 3; i++) m_keep[i] = '0;
        end else begin
            wa = wr_en && wr_addr == 2'd0 && wr_data[6];
            ws = wr_en && wr_addr == 2'd1 && wr_data[6];
            rf = ws && m_armed && (m_arm > 0);
            ld = (ws && !m_run) || rf;
            ex = m_run && m_cnt == 1 && !ld;
            m_rr = ex;
            if (wr_en && wr_addr != 2'd3) m_keep[wr_addr] = wr_data & 8'hBF;
            m_armed = ex ? 1'b0 : (wr_en ? wa : (m_armed && m_arm > 0));
            m_arm = ex ? 0 : (wa ? CLR : (m_arm > 0 ? m_arm - 1 : 0));
            m_st  = ex ? 0 : (ws ? CLR : (m_st  > 0 ? m_st  - 1 : 0));
            if (ld) begin m_run = 1; m_cnt = TO; end
            else if (ex) begin m_run = 0; m_cnt = 0; end
            else if (m_run) m_cnt = m_cnt - 1;
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_keep[0] | ((m_arm > 0) ? 8'h40 : 8'h00);
            2'd1: return m_keep[1] | ((m_st  > 0) ? 8'h40 : 8'h00);
            2'd2: return m_keep[2] | (m_run ? 8'h40 : 8'h00);
            default: return 8'h00;
        endcase
    endfunction

    // compare every cycle on the falling edge, then step the read address
    always @(negedge clk) begin
        if (chk_on) begin
            n_cmp++;
            if (rst_req !== m_rr) begin
                n_bad++;
                $display("FAIL %s rst_req got %b exp %b at %0t", cur_req, rst_req, m_rr, $time);
            end
            n_cmp++;
            if (rd_data !== model_rd(rd_addr)) begin
                n_bad++;
                $display("FAIL %s rd_data[addr %0d] got %h exp %h at %0t",
                         cur_req, rd_addr, rd_data, model_rd(rd_addr), $time);
            end
            rd_addr = rd_addr + 2'd1;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        cur_req = "R1"; idle(8);
        cur_req = "R2";
        wr(2'd2, 8'hBF); wr(2'd0, 8'h85); wr(2'd1, 8'h2A); wr(2'd3, 8'hFF);
        idle(8);
        cur_req = "R3";
        wr(2'd0, 8'hC5); idle(5); wr(2'd0, 8'h45); idle(4);
        wr(2'd0, 8'h05); idle(16);
        cur_req = "R4";
        wr(2'd1, 8'h6A); idle(3); wr(2'd1, 8'h2A); idle(4);
        cur_req = "R5";
        wr(2'd2, 8'h00); idle(3); wr(2'd2, 8'hFF); idle(6);
        cur_req = "R7";
        wr(2'd0, 8'h40); wr(2'd1, 8'h40); idle(20);
        wr(2'd0, 8'h41); wr(2'd1, 8'h42); idle(10);
        cur_req = "R8";
        wr(2'd1, 8'h40); idle(5);
        wr(2'd0, 8'h40); wr(2'd3, 8'h00); wr(2'd1, 8'h40); idle(5);
        wr(2'd0, 8'h40); wr(2'd2, 8'h11); wr(2'd1, 8'h40); idle(3);
        cur_req = "R7";
        wr(2'd0, 8'h40); wr(2'd1, 8'h40); idle(2);
        cur_req = "R9";
        wr(2'd0, 8'h40); idle(14); wr(2'd1, 8'h40); idle(2);
        cur_req = "R11";
        while (m_cnt != 4) @(negedge clk);
        wr(2'd0, 8'h40); wr(2'd1, 8'h40); idle(6);
        cur_req = "R6";
        idle(TO - 12);
        cur_req = "R10";
        idle(12);
        cur_req = "R6";
        wr(2'd1, 8'h40); idle(TO + 4);
        cur_req = "R10";
        idle(4);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end
endmodule